// File: doc/BRIEF.md
# Packet-to-Effect Dispatch Unit

This block sits between a core's local network-on-chip router port and the core's pipeline. It turns each arriving packet into a synthetic effect-perform in the hardware family 0xF, so that no separate interrupt line is needed. Packets are queued in a small FIFO, and a pending-effect request is raised toward the core while one is waiting. The core answers with a boundary strobe at its preemption sample point, that is, between instructions. On that strobe the head packet is looked up in an 8-entry handler table keyed by (family, op). The block then presents the handler address together with the values the pipeline loads into its argument registers: the payload for v0, the continuation reference for v1 and the op for v7.

Software fills the handler table through a simple install port. An entry can name an exact op, or it can act as a wildcard that covers every op of its family. A wildcard entry in family 0xF is the outermost catch-all, so that stray packets are still dispatched. If no entry matches at all, the block pulses a no-handler fault and drops the packet. The queue keeps moving in that case and never stalls.

Top module: `pktfx_top`

## Requirements
- R1: After reset, pktReady=1, effReq=0, dispValid=0 and noHandler=0, and the handler table holds no valid entry. A packet dispatched before any install therefore raises noHandler.
- R2: The arrival FIFO holds 4 packets. pktReady is 0 while 4 are queued. A packet offered while pktReady=0 is discarded.
- R3: effReq is 1 exactly when at least one packet is queued and no dispatch is outstanding (dispValid=0).
- R4: A packet leaves the FIFO only on a clock edge where boundary=1 and effReq=1. Its dispatch outputs are visible from the following cycle.
- R5: An entry gives an exact match when it is valid, its family field equals 0xF, its wildcard bit is 0 and its op field equals the packet's 4-bit op. An entry whose family is not 0xF never matches.
- R6: Any exact match takes priority over any wildcard match. Within each class, the entry with the lowest index wins.
- R7: A valid entry with family 0xF and wildcard bit 1 matches every op.
- R8: When no entry matches, the boundary edge produces a one-cycle noHandler pulse instead of a dispatch, and the packet is removed from the FIFO.
- R9: On dispatch, dispTarget is loaded with the handler address, dispPayload with the packet payload (v0), dispCont with contRef as sampled at the boundary edge (v1), and dispOp with the packet op (v7). These outputs and dispValid hold until an edge with dispAck=1, after which dispValid is 0. A boundary strobe while dispValid=1 has no effect.
- R10: Packets are dispatched in the order they were accepted.
- R11: An install edge (instEn=1) writes entry instIdx with instValid, instFamily, instOp, instWild and instTarget. The written entry governs lookups from the next edge on. Writing instValid=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | Router offers a packet |
| pktReady | output | 1 | FIFO has room; packet accepted when both are high |
| pktOp | input | 4 | Op field of the offered packet |
| pktPayload | input | 32 | Payload of the offered packet |
| effReq | output | 1 | Pending-effect request toward the core |
| boundary | input | 1 | Core is at an instruction boundary and takes a request |
| contRef | input | 32 | Continuation reference from the core, for v1 |
| dispValid | output | 1 | Dispatch outputs are valid |
| dispTarget | output | 32 | Handler address |
| dispPayload | output | 32 | Value for v0 |
| dispOp | output | 4 | Value for v7 |
| dispCont | output | 32 | Value for v1 |
| dispAck | input | 1 | Core has taken the dispatch |
| noHandler | output | 1 | One-cycle fault pulse: the packet had no handler and was dropped |
| instEn | input | 1 | Install strobe |
| instIdx | input | 3 | Table entry to write |
| instValid | input | 1 | Valid bit to write |
| instFamily | input | 4 | Family field to write |
| instOp | input | 4 | Op field to write |
| instWild | input | 1 | Op-wildcard bit to write |
| instTarget | input | 32 | Handler address to write |

## Verification
Every result of this block is due one clock after the edge that causes it. pktReady and effReq move one cycle after the accept or dispatch edge. The dispatch fields or the noHandler pulse appear one cycle after the boundary edge, and dispValid falls one cycle after the acknowledging edge. A table write takes effect for the lookup at the following edge. The bench drives inputs and samples outputs on the falling edge. It advances a behavioural queue-and-table model at each rising edge, so every comparison lands in the cycle where the result is due. Directed sequences then check fixed handler addresses, payload order, a full queue and a dropped packet against values worked out by hand.

// File: rtl/pktfx_pkg.sv
package pktfx_pkg;
  // Width of the effect family field and the family reserved for hardware.
  localparam int FAM_W = 4;
  localparam logic [FAM_W-1:0] HW_FAMILY = 4'hF;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;     // write arriving packet into the FIFO
    logic pop;      // retire FIFO head (dispatched or dropped)
    logic loadOut;  // capture dispatch output registers
  } pfxStrobe_t;
endpackage

// File: rtl/pktfx_cam.sv
module pktfx_cam
  import pktfx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int OP_W    = 4,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(ENTRIES)-1:0] wrIdx,
  input  logic                       wrValid,
  input  logic [FAM_W-1:0]           wrFamily,
  input  logic [OP_W-1:0]            wrOp,
  input  logic                       wrWild,
  input  logic [ADDR_W-1:0]          wrTarget,
  input  logic [FAM_W-1:0]           lookFamily,
  input  logic [OP_W-1:0]            lookOp,
  output logic                       hit,
  output logic [ADDR_W-1:0]          hitTarget
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] exactVec;
  logic [ENTRIES-1:0] wildVec;
  logic [ADDR_W-1:0]  tgtArr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              vld;
    logic              wild;
    logic [FAM_W-1:0]  fam;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] tgt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld  <= 1'b0;
        wild <= 1'b0;
        fam  <= '0;
        op   <= '0;
        tgt  <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(g))) begin
        vld  <= wrValid;
        wild <= wrWild;
        fam  <= wrFamily;
        op   <= wrOp;
        tgt  <= wrTarget;
      end
    end

    assign validVec[g] = vld;
    assign exactVec[g] = vld && (fam == lookFamily) && !wild && (op == lookOp);
    assign wildVec[g]  = vld && (fam == lookFamily) && wild;
    assign tgtArr[g]   = tgt;
  end

  // Wildcards resolved first, exact matches then override; descending
  // scans leave the lowest index in place within each class.
  always_comb begin
    hit       = 1'b0;
    hitTarget = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wildVec[i]) begin
        hit       = 1'b1;
        hitTarget = tgtArr[i];
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (exactVec[i]) begin
        hit       = 1'b1;
        hitTarget = tgtArr[i];
      end
    end
  end

  // R1: table comes out of reset with no valid entry
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (validVec == '0));
endmodule

// File: rtl/pktfx_datapath.sv
module pktfx_datapath
  import pktfx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ENTRIES = 8,
  parameter int OP_W    = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pfxStrobe_t                 str,
  input  logic [OP_W-1:0]            pktOp,
  input  logic [DATA_W-1:0]          pktPayload,
  input  logic [ADDR_W-1:0]          contRef,
  input  logic                       instEn,
  input  logic [$clog2(ENTRIES)-1:0] instIdx,
  input  logic                       instValid,
  input  logic [FAM_W-1:0]           instFamily,
  input  logic [OP_W-1:0]            instOp,
  input  logic                       instWild,
  input  logic [ADDR_W-1:0]          instTarget,
  output logic                       headHit,
  output logic [ADDR_W-1:0]          dispTarget,
  output logic [DATA_W-1:0]          dispPayload,
  output logic [OP_W-1:0]            dispOp,
  output logic [ADDR_W-1:0]          dispCont
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [OP_W-1:0]   opMem  [DEPTH];
  logic [DATA_W-1:0] payMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [ADDR_W-1:0] camTarget;

  always_ff @(posedge clk) begin
    if (str.push) begin
      opMem[wrPtr]  <= pktOp;
      payMem[wrPtr] <= pktPayload;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (str.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (str.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  pktfx_cam #(
    .ENTRIES(ENTRIES), .OP_W(OP_W), .ADDR_W(ADDR_W)
  ) cam_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (instEn),
    .wrIdx     (instIdx),
    .wrValid   (instValid),
    .wrFamily  (instFamily),
    .wrOp      (instOp),
    .wrWild    (instWild),
    .wrTarget  (instTarget),
    .lookFamily(HW_FAMILY),
    .lookOp    (opMem[rdPtr]),
    .hit       (headHit),
    .hitTarget (camTarget)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispTarget  <= '0;
      dispPayload <= '0;
      dispOp      <= '0;
      dispCont    <= '0;
    end else if (str.loadOut) begin
      dispTarget  <= camTarget;
      dispPayload <= payMem[rdPtr];
      dispOp      <= opMem[rdPtr];
      dispCont    <= contRef;
    end
  end
endmodule

// File: rtl/pktfx_ctrl.sv
module pktfx_ctrl
  import pktfx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktValid,
  input  logic       boundary,
  input  logic       dispAck,
  input  logic       headHit,
  output logic       pktReady,
  output logic       effReq,
  output logic       dispValid,
  output logic       noHandler,
  output pfxStrobe_t str
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;

  assign pktReady = (count != CNT_W'(DEPTH));
  assign effReq   = (count != '0) && !dispValid;

  always_comb begin
    str.push    = pktValid && pktReady;
    str.pop     = boundary && effReq;
    str.loadOut = str.pop && headHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      dispValid <= 1'b0;
      noHandler <= 1'b0;
    end else begin
      case ({str.push, str.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (str.loadOut)  dispValid <= 1'b1;
      else if (dispAck) dispValid <= 1'b0;
      noHandler <= str.pop && !headHit;
    end
  end

  // R2: a refused offer leaves the queue full unless the head retired
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktReady == $past(str.pop)));

  // R4: dispatch only follows a boundary edge
  p_boundary_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispValid) |-> $past(boundary));

  // R8: a fault pulse comes only from a boundary edge
  p_fault_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    noHandler |-> $past(boundary));

  // R9: acknowledge retires the dispatch
  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispAck) |=> !dispValid);
endmodule

// File: rtl/pktfx_top.sv
module pktfx_top
  import pktfx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ENTRIES = 8,
  parameter int OP_W    = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pktValid,
  output logic                       pktReady,
  input  logic [OP_W-1:0]            pktOp,
  input  logic [DATA_W-1:0]          pktPayload,
  output logic                       effReq,
  input  logic                       boundary,
  input  logic [ADDR_W-1:0]          contRef,
  output logic                       dispValid,
  output logic [ADDR_W-1:0]          dispTarget,
  output logic [DATA_W-1:0]          dispPayload,
  output logic [OP_W-1:0]            dispOp,
  output logic [ADDR_W-1:0]          dispCont,
  input  logic                       dispAck,
  output logic                       noHandler,
  input  logic                       instEn,
  input  logic [$clog2(ENTRIES)-1:0] instIdx,
  input  logic                       instValid,
  input  logic [FAM_W-1:0]           instFamily,
  input  logic [OP_W-1:0]            instOp,
  input  logic                       instWild,
  input  logic [ADDR_W-1:0]          instTarget
);
  pfxStrobe_t str;
  logic       headHit;

  pktfx_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pktValid (pktValid),
    .boundary (boundary),
    .dispAck  (dispAck),
    .headHit  (headHit),
    .pktReady (pktReady),
    .effReq   (effReq),
    .dispValid(dispValid),
    .noHandler(noHandler),
    .str      (str)
  );

  pktfx_datapath #(
    .DEPTH(DEPTH), .ENTRIES(ENTRIES), .OP_W(OP_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .pktOp      (pktOp),
    .pktPayload (pktPayload),
    .contRef    (contRef),
    .instEn     (instEn),
    .instIdx    (instIdx),
    .instValid  (instValid),
    .instFamily (instFamily),
    .instOp     (instOp),
    .instWild   (instWild),
    .instTarget (instTarget),
    .headHit    (headHit),
    .dispTarget (dispTarget),
    .dispPayload(dispPayload),
    .dispOp     (dispOp),
    .dispCont   (dispCont)
  );

  // R9: outputs frozen while waiting for the acknowledge
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispAck) |=> (dispValid && $stable(dispTarget) &&
      $stable(dispPayload) && $stable(dispOp) && $stable(dispCont)));

  // R8: a dropped packet never coexists with a live dispatch
  p_fault_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    noHandler |-> !dispValid);
endmodule

// File: tb/pktfx_top_tb_top.sv
`timescale 1ns/1ps
module pktfx_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic        pktReady;
  logic [3:0]  pktOp = '0;
  logic [31:0] pktPayload = '0;
  logic        effReq;
  logic        boundary = 1'b0;
  logic [31:0] contRef = '0;
  logic        dispValid;
  logic [31:0] dispTarget, dispPayload, dispCont;
  logic [3:0]  dispOp;
  logic        dispAck = 1'b0;
  logic        noHandler;
  logic        instEn = 1'b0;
  logic [2:0]  instIdx = '0;
  logic        instValid = 1'b0;
  logic [3:0]  instFamily = '0;
  logic [3:0]  instOp = '0;
  logic        instWild = 1'b0;
  logic [31:0] instTarget = '0;

  always #2.5 clk = ~clk;

  pktfx_top dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [3:0] op; logic [31:0] pay; } pkt_t;
  pkt_t        q[$];
  bit          tV[8], tW[8];
  logic [3:0]  tF[8], tO[8];
  logic [31:0] tT[8];
  bit          mDisp, mFault;
  logic [31:0] mTgt, mPay, mCont;
  logic [3:0]  mOp;

  function automatic int lookup(input logic [3:0] op);
    for (int i = 0; i < 8; i++) if (tV[i] && tF[i] == 4'hF && !tW[i] && tO[i] == op) return i;
    for (int i = 0; i < 8; i++) if (tV[i] && tF[i] == 4'hF && tW[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    bit rdy, req;
    int h;
    pkt_t p;
    if (!rstN) begin
      q.delete();
      for (int i = 0; i < 8; i++) tV[i] = 0;
      mDisp = 0; mFault = 0;
    end else begin
      rdy = q.size() < 4;
      req = q.size() > 0 && !mDisp;
      mFault = 0;
      if (mDisp && dispAck) mDisp = 0;
      if (boundary && req) begin
        p = q.pop_front();
        h = lookup(p.op);
        if (h >= 0) begin
          mDisp = 1; mTgt = tT[h]; mPay = p.pay; mOp = p.op; mCont = contRef;
        end else mFault = 1;
      end
      if (pktValid && rdy) begin
        p.op = pktOp; p.pay = pktPayload; q.push_back(p);
      end
      if (instEn) begin
        tV[instIdx] = instValid; tW[instIdx] = instWild; tF[instIdx] = instFamily;
        tO[instIdx] = instOp; tT[instIdx] = instTarget;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(pktReady == (q.size() < 4), "R2 model pktReady", pktReady, q.size() < 4);
      check(effReq == (q.size() > 0 && !mDisp), "R3 model effReq", effReq, q.size() > 0 && !mDisp);
      check(dispValid == mDisp, "R4 model dispValid", dispValid, mDisp);
      check(noHandler == mFault, "R8 model noHandler", noHandler, mFault);
      if (mDisp) begin
        check(dispTarget == mTgt, "R6 model dispTarget", dispTarget, mTgt);
        check(dispPayload == mPay, "R9 model dispPayload", dispPayload, mPay);
        check(dispOp == mOp, "R9 model dispOp", dispOp, mOp);
        check(dispCont == mCont, "R9 model dispCont", dispCont, mCont);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic install(input int idx, input bit v, input logic [3:0] fam,
                         input logic [3:0] op, input bit wild, input logic [31:0] tgt);
    @(negedge clk);
    instEn = 1; instIdx = idx[2:0]; instValid = v; instFamily = fam;
    instOp = op; instWild = wild; instTarget = tgt;
    @(negedge clk);
    instEn = 0;
  endtask

  task automatic sendPkt(input logic [3:0] op, input logic [31:0] pay);
    @(negedge clk);
    pktValid = 1; pktOp = op; pktPayload = pay;
    @(negedge clk);
    pktValid = 0;
  endtask

  task automatic doBoundary(input logic [31:0] cont);
    @(negedge clk);
    boundary = 1; contRef = cont;
    @(negedge clk);
    boundary = 0;
  endtask

  task automatic doAck();
    @(negedge clk);
    dispAck = 1;
    @(negedge clk);
    dispAck = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [31:0] TGT_A = 32'h0000_1000, TGT_B = 32'h0000_2000,
                          TGT_W = 32'h0000_F000, TGT_X = 32'h0000_E000,
                          TGT_C = 32'h0000_3000, TGT_D = 32'h0000_4000;

  initial begin
    idle(3);
    rstN = 1;
    @(negedge clk);
    check(pktReady == 1, "R1 reset pktReady", pktReady, 1);
    check(effReq == 0, "R1 reset effReq", effReq, 0);
    check(dispValid == 0, "R1 reset dispValid", dispValid, 0);
    check(noHandler == 0, "R1 reset noHandler", noHandler, 0);

    // empty table: fault and drop
    sendPkt(4'h3, 32'hAAAA_0001);
    check(effReq == 1, "R3 queued request", effReq, 1);
    doBoundary(32'hC0);
    check(noHandler == 1, "R1 empty table fault", noHandler, 1);
    check(dispValid == 0, "R8 no dispatch on miss", dispValid, 0);
    @(negedge clk);
    check(noHandler == 0, "R8 fault is one cycle", noHandler, 0);
    check(effReq == 0, "R8 packet dropped", effReq, 0);

    // populate table
    install(5, 1, 4'hF, 4'h3, 0, TGT_A);
    install(2, 1, 4'hF, 4'h0, 1, TGT_W);
    install(6, 1, 4'hF, 4'h3, 0, TGT_B);
    install(1, 1, 4'hE, 4'h7, 0, TGT_X);
    install(7, 1, 4'hF, 4'hA, 0, TGT_D);

    sendPkt(4'h3, 32'h0000_0041);
    doBoundary(32'h1111_0000);
    check(dispValid == 1, "R4 dispatch after boundary", dispValid, 1);
    check(dispTarget == TGT_A, "R6 lowest exact entry wins", dispTarget, TGT_A);
    check(dispPayload == 32'h41, "R9 payload to v0", dispPayload, 32'h41);
    check(dispOp == 4'h3, "R9 op to v7", dispOp, 4'h3);
    check(dispCont == 32'h1111_0000, "R9 cont to v1", dispCont, 32'h1111_0000);
    // boundary while outstanding has no effect
    sendPkt(4'h9, 32'h0000_0099);
    doBoundary(32'h2222_0000);
    check(dispPayload == 32'h41, "R9 held under boundary", dispPayload, 32'h41);
    check(effReq == 0, "R3 no request while outstanding", effReq, 0);
    doAck();
    check(dispValid == 0, "R9 ack clears", dispValid, 0);
    check(effReq == 1, "R3 request resumes", effReq, 1);

    // R4: no boundary, no dispatch
    idle(5);
    check(dispValid == 0, "R4 waits for boundary", dispValid, 0);
    doBoundary(32'h3333_0000);
    check(dispTarget == TGT_W, "R7 wildcard catches op 9", dispTarget, TGT_W);
    doAck();

    sendPkt(4'h7, 32'h77);
    doBoundary(32'h4);
    check(dispTarget == TGT_W, "R5 other family ignored", dispTarget, TGT_W);
    doAck();

    sendPkt(4'hA, 32'hAA);
    doBoundary(32'h5);
    check(dispTarget == TGT_D, "R6 exact beats lower wildcard", dispTarget, TGT_D);
    doAck();

    // R2 / R10: burst of five
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      pktValid = 1; pktOp = 4'(i); pktPayload = 32'h100 + i;
    end
    @(negedge clk);
    pktValid = 0;
    check(pktReady == 0, "R2 full after four", pktReady, 0);
    for (int i = 1; i <= 4; i++) begin
      doBoundary(32'h500 + i);
      check(dispPayload == 32'h100 + i, "R10 arrival order", dispPayload, 32'h100 + i);
      doAck();
    end
    check(effReq == 0, "R2 fifth packet discarded", effReq, 0);

    // R11: install takes effect, removal works
    install(0, 1, 4'hF, 4'h9, 0, TGT_C);
    sendPkt(4'h9, 32'h9);
    doBoundary(32'h6);
    check(dispTarget == TGT_C, "R11 new entry used", dispTarget, TGT_C);
    doAck();
    install(2, 0, 4'hF, 4'h0, 1, TGT_W);
    sendPkt(4'hB, 32'hB);
    doBoundary(32'h7);
    check(noHandler == 1, "R11 removed wildcard gives fault", noHandler, 1);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule